// File: doc/BRIEF.md
# MSI Interrupt Request Handler

This block sits between the interrupt sources of an endpoint and the message-signalled interrupt port of a PCI Express core. Three kinds of source feed it: a system-error pulse, a hot-plug/power-management pulse, and a bank of application event pulses. Each event sets a sticky pending bit on the message vector it maps to. The block then raises one request at a time toward the core, with a message number and a traffic class, and holds that request until the core acknowledges it.

The vector map follows the number of message vectors that software actually granted. This number is given as a base-2 logarithm and can be smaller than the number the function asked for. The system sources take the top of the granted range. Application events whose index lies above the range left for them are folded onto the highest application vector. In this way an ungranted number is never sent. A parameter chooses whether the two system sources get separate vectors or share the top one. Requests go out only while the MSI enable is set and the legacy wire interrupt is switched off in the command register.

Top module: `msi_req_arb`

## Requirements
- R1: After reset `msi_req` is 0, `msi_num` and `msi_tc` are 0, and no vector is pending, so no request appears until a new event arrives.
- R2: With 32 vectors granted (`alloc_log2` = 5), a system error maps to vector 31, a hot-plug/power-management event maps to vector 30, and application event i maps to vector i.
- R3: With SHARE_SYS = 0 and N = 2^`alloc_log2` (values above 5 act as 5): system error goes to N-1; hot-plug/power-management goes to N-2, or to 0 when N = 1; application event i goes to min(i, N-3), or to 0 when N <= 2.
- R4: With SHARE_SYS = 1, both system sources go to vector N-1, and application event i goes to min(i, N-2), or to 0 when N = 1.
- R5: `msi_num` is always below N while `msi_req` is high.
- R6: A vector that carries the system-error or hot-plug/power-management role is sent with traffic class 0. Every other vector v is sent with `vec_tc[3v+2:3v]`.
- R7: A request is raised only while `msi_en` is 1 and `intx_disable` is 1. If either input drops while a request is not yet acknowledged, `msi_req` is low from the next cycle. The pending bit is kept, and the request is raised again once both inputs are 1.
- R8: A pending vector v with `vec_en[v]` = 0 is not signalled. It stays pending and is signalled after `vec_en[v]` is set.
- R9: Any number of events on the same vector before that vector is acknowledged produce exactly one request.
- R10: When several enabled vectors are pending, the highest vector number is requested first.
- R11: `msi_num` and `msi_tc` stay stable from the rise of `msi_req` until `msi_ack` is sampled high. `msi_req` is low in the cycle after that. No new request rises while `msi_ack` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_en | input | 1 | MSI enable from configuration space |
| intx_disable | input | 1 | Command register bit 10: legacy wire interrupt off |
| alloc_log2 | input | LW (3) | Base-2 logarithm of the number of granted vectors |
| vec_en | input | MAX_VEC (32) | Per-vector enable |
| vec_tc | input | MAX_VEC*TCW (96) | Per-vector traffic class; vector v uses bits [3v+2:3v] |
| sys_err_evt | input | 1 | System-error event pulse |
| hotplug_pm_evt | input | 1 | Hot-plug / power-management event pulse |
| app_evt | input | NUM_APP (30) | Application event pulses, one per index |
| msi_ack | input | 1 | Acknowledge from the core |
| msi_req | output | 1 | Interrupt request to the core |
| msi_num | output | VW (5) | Message number of the current request |
| msi_tc | output | TCW (3) | Traffic class of the current request |

## Verification
A pending bit that is not cleared on acknowledge shows up as a duplicate request with the same number. It appears at the ports two cycles after the acknowledge drops. A lost pending bit shows up as a missing request when the scoreboard drains. A wrong fold or a wrong system-vector position appears at once as a wrong `msi_num` on the next rising request. A priority fault appears as a wrong order among requests that were pending together. A request register that fails to drop on acknowledge or on loss of enable is visible one cycle later.

// File: rtl/msi_req_arb.sv
module msi_req_arb #(
  parameter int NUM_APP   = 30,
  parameter bit SHARE_SYS = 1'b0,
  parameter int MAX_VEC   = 32,
  parameter int TCW       = 3,
  localparam int VW = $clog2(MAX_VEC),
  localparam int LW = $clog2(VW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msi_en,
  input  logic                   intx_disable,
  input  logic [LW-1:0]          alloc_log2,
  input  logic [MAX_VEC-1:0]     vec_en,
  input  logic [MAX_VEC*TCW-1:0] vec_tc,
  input  logic                   sys_err_evt,
  input  logic                   hotplug_pm_evt,
  input  logic [NUM_APP-1:0]     app_evt,
  input  logic                   msi_ack,
  output logic                   msi_req,
  output logic [VW-1:0]          msi_num,
  output logic [TCW-1:0]         msi_tc
);

  localparam int RSV = SHARE_SYS ? 1 : 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE} st_t;
  st_t st;

  logic [MAX_VEC-1:0] pend, set_m, clr_m, cand;
  logic [VW-1:0]      sys_vec, hp_vec, app_top, pick;
  logic               gate, any;
  int                 n_alloc;

  always_comb begin
    n_alloc = 1 << ((int'(alloc_log2) > VW) ? VW : int'(alloc_log2));
    sys_vec = VW'(n_alloc - 1);
    hp_vec  = (n_alloc > 1 && !SHARE_SYS) ? VW'(n_alloc - 2) : sys_vec;
    app_top = (n_alloc > RSV) ? VW'(n_alloc - RSV - 1) : '0;
  end

  always_comb begin
    set_m = '0;
    for (int i = 0; i < NUM_APP; i++)
      if (app_evt[i]) begin
        if (i > int'(app_top)) set_m[app_top] = 1'b1;
        else                   set_m[VW'(i)]  = 1'b1;
      end
    if (sys_err_evt)    set_m[sys_vec] = 1'b1;
    if (hotplug_pm_evt) set_m[hp_vec]  = 1'b1;
  end

  assign cand  = pend & vec_en;
  assign any   = |cand;
  assign gate  = msi_en & intx_disable;
  assign clr_m = (st == S_REQ && msi_ack) ? (MAX_VEC'(1) << msi_num) : '0;

  always_comb begin
    pick = '0;
    for (int v = 0; v < MAX_VEC; v++)
      if (cand[v]) pick = VW'(v);
  end

  wire sys_role = (pick == sys_vec) || (pick == hp_vec);
  wire [TCW-1:0] tc_pick = sys_role ? '0 : vec_tc[int'(pick)*TCW +: TCW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      msi_req <= 1'b0;
      msi_num <= '0;
      msi_tc  <= '0;
      pend    <= '0;
    end else begin
      pend <= (pend & ~clr_m) | set_m;
      case (st)
        S_IDLE:
          if (gate && any) begin
            msi_req <= 1'b1;
            msi_num <= pick;
            msi_tc  <= tc_pick;
            st      <= S_REQ;
          end
        S_REQ:
          if (msi_ack) begin
            msi_req <= 1'b0;
            st      <= S_DONE;
          end else if (!gate) begin
            msi_req <= 1'b0;
            st      <= S_IDLE;
          end
        S_DONE:
          if (!msi_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module msi_req_arb_chk #(
  parameter int MAX_VEC = 32,
  parameter int TCW     = 3,
  localparam int VW = $clog2(MAX_VEC),
  localparam int LW = $clog2(VW + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msi_en,
  input logic               intx_disable,
  input logic [LW-1:0]      alloc_log2,
  input logic [MAX_VEC-1:0] vec_en,
  input logic               msi_ack,
  input logic               msi_req,
  input logic [VW-1:0]      msi_num,
  input logic [TCW-1:0]     msi_tc
);
  logic [MAX_VEC-1:0] en_q;
  int n_vec;
  wire on = msi_en & intx_disable;

  always_comb n_vec = (int'(alloc_log2) >= VW) ? MAX_VEC : (1 << int'(alloc_log2));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= vec_en;

  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) msi_req |-> int'(msi_num) < n_vec); // R5
  AST_TOP_TC_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (msi_req && int'(msi_num) == n_vec - 1) |-> msi_tc == '0); // R6
  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (msi_req && !msi_ack && on) |=> (msi_req && $stable(msi_num) && $stable(msi_tc))); // R11
  AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) (msi_req && msi_ack) |=> !msi_req); // R11
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !on |=> !msi_req); // R7
  AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(msi_req) |-> en_q[msi_num]); // R8
endmodule

bind msi_req_arb msi_req_arb_chk #(.MAX_VEC(MAX_VEC), .TCW(TCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .intx_disable(intx_disable),
  .alloc_log2(alloc_log2), .vec_en(vec_en), .msi_ack(msi_ack),
  .msi_req(msi_req), .msi_num(msi_num), .msi_tc(msi_tc)
);

// File: tb/sim_msi_req_arb.sv
module sim_msi_req_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic msi_en = 1'b0, intx_disable = 1'b0;
  logic [2:0] alloc_log2 = 3'd5;
  logic [31:0] vec_en = '1;
  logic [95:0] vec_tc = '0;
  logic sys_err_evt = 1'b0, hotplug_pm_evt = 1'b0;
  logic [29:0] app_evt = '0;
  logic msi_ack = 1'b0, ack1 = 1'b0;
  logic msi_req, req1;
  logic [4:0] msi_num, num1;
  logic [2:0] msi_tc, tc1;

  int total = 0, bad = 0;
  bit mon_on = 1'b1;
  int ack_lat = 1, ack_len = 1;
  int q_num[$], q_tc[$];
  string q_tag[$];
  int l1_num[$], l1_tc[$];

  always #2 clk = ~clk;

  msi_req_arb u0 (.clk(clk), .rst_n(rst_n), .msi_en(msi_en), .intx_disable(intx_disable),
    .alloc_log2(alloc_log2), .vec_en(vec_en), .vec_tc(vec_tc), .sys_err_evt(sys_err_evt),
    .hotplug_pm_evt(hotplug_pm_evt), .app_evt(app_evt), .msi_ack(msi_ack),
    .msi_req(msi_req), .msi_num(msi_num), .msi_tc(msi_tc));

  msi_req_arb #(.SHARE_SYS(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .msi_en(msi_en),
    .intx_disable(intx_disable), .alloc_log2(alloc_log2), .vec_en(vec_en), .vec_tc(vec_tc),
    .sys_err_evt(sys_err_evt), .hotplug_pm_evt(hotplug_pm_evt), .app_evt(app_evt),
    .msi_ack(ack1), .msi_req(req1), .msi_num(num1), .msi_tc(tc1));

  function automatic int tcv(int v);
    return (v * 3 + 1) % 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_req(input int num, input int tc, input string tag);
    q_num.push_back(num); q_tc.push_back(tc); q_tag.push_back(tag);
  endtask

  task automatic pulse_app(input int i);
    @(negedge clk); app_evt[i] = 1'b1;
    @(negedge clk); app_evt = '0;
  endtask

  task automatic pulse_sys();
    @(negedge clk); sys_err_evt = 1'b1;
    @(negedge clk); sys_err_evt = 1'b0;
  endtask

  task automatic pulse_hp();
    @(negedge clk); hotplug_pm_evt = 1'b1;
    @(negedge clk); hotplug_pm_evt = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((q_num.size() != 0 || msi_req || msi_ack) && n < 300) begin
      @(negedge clk); n++;
    end
    repeat (10) @(negedge clk);
    chk(q_num.size() == 0, tag, "requests still missing", q_num.size(), 0);
  endtask

  // scoreboard monitor on u0
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && msi_req && !msi_ack) begin
        if (q_num.size() == 0) begin
          chk(1'b0, "R9", "unexpected request num", int'(msi_num), -1);
        end else begin
          int e_num, e_tc;
          string e_tag;
          e_num = q_num.pop_front(); e_tc = q_tc.pop_front(); e_tag = q_tag.pop_front();
          chk(int'(msi_num) == e_num, e_tag, "msi_num", int'(msi_num), e_num);
          chk(int'(msi_tc) == e_tc, "R6", "msi_tc", int'(msi_tc), e_tc);
          for (int k = 1; k < ack_lat; k++) begin
            @(negedge clk);
            chk(msi_req && int'(msi_num) == e_num, "R11", "request held before ack", int'(msi_num), e_num);
          end
        end
        msi_ack = 1'b1;
        for (int k = 0; k < ack_len; k++) begin
          @(negedge clk);
          chk(!msi_req, "R11", "req low after ack", int'(msi_req), 0);
        end
        msi_ack = 1'b0;
      end
    end
  end

  // automatic acknowledge and log for u1
  always @(negedge clk) begin
    if (rst_n && req1 && !ack1) begin
      l1_num.push_back(int'(num1)); l1_tc.push_back(int'(tc1));
    end
    ack1 <= rst_n && req1 && !ack1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < 32; v++) vec_tc[v*3 +: 3] = 3'(tcv(v));
    repeat (5) @(negedge clk);
    chk(!msi_req, "R1", "req in reset", int'(msi_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!msi_req && msi_num == 0 && msi_tc == 0, "R1", "outputs after reset", int'(msi_num), 0);
    msi_en = 1'b1; intx_disable = 1'b1;
    repeat (6) @(negedge clk);
    chk(!msi_req, "R1", "no request without events", int'(msi_req), 0);

    // R2 full allocation
    expect_req(5, tcv(5), "R2");  pulse_app(5);  drain("R2");
    expect_req(31, 0, "R2");      pulse_sys();   drain("R2");
    expect_req(30, 0, "R2");      pulse_hp();    drain("R2");
    expect_req(29, tcv(29), "R2"); pulse_app(29); drain("R2");

    // R10 priority
    msi_en = 1'b0;
    pulse_app(3); pulse_app(7); pulse_sys();
    expect_req(31, 0, "R10"); expect_req(7, tcv(7), "R10"); expect_req(3, tcv(3), "R10");
    @(negedge clk); msi_en = 1'b1;
    drain("R10");

    // R9 merge
    msi_en = 1'b0;
    pulse_app(4); pulse_app(4); pulse_app(4);
    expect_req(4, tcv(4), "R9");
    @(negedge clk); msi_en = 1'b1;
    drain("R9");

    // R8 per-vector enable
    vec_en[6] = 1'b0;
    pulse_app(6);
    repeat (12) @(negedge clk);
    chk(!msi_req, "R8", "disabled vector signalled", int'(msi_req), 0);
    expect_req(6, tcv(6), "R8");
    vec_en[6] = 1'b1;
    drain("R8");

    // R11 long acknowledge and slow acknowledge
    ack_len = 4; ack_lat = 3;
    msi_en = 1'b0;
    pulse_app(2); pulse_app(1);
    expect_req(2, tcv(2), "R11"); expect_req(1, tcv(1), "R11");
    @(negedge clk); msi_en = 1'b1;
    drain("R11");
    ack_len = 1; ack_lat = 1;

    // R7 enable drop while outstanding
    mon_on = 1'b0;
    pulse_app(9);
    for (int n = 0; n < 10 && !msi_req; n++) @(negedge clk);
    chk(msi_req && msi_num == 9, "R7", "request before drop", int'(msi_num), 9);
    msi_en = 1'b0;
    @(negedge clk);
    chk(!msi_req, "R7", "req after enable drop", int'(msi_req), 0);
    repeat (5) @(negedge clk);
    chk(!msi_req, "R7", "req while disabled", int'(msi_req), 0);
    expect_req(9, tcv(9), "R7");
    mon_on = 1'b1; msi_en = 1'b1;
    drain("R7");
    intx_disable = 1'b0;
    pulse_app(8);
    repeat (10) @(negedge clk);
    chk(!msi_req, "R7", "req with legacy interrupt on", int'(msi_req), 0);
    expect_req(8, tcv(8), "R7");
    intx_disable = 1'b1;
    drain("R7");

    // R3 / R4 / R5 four vectors
    alloc_log2 = 3'd2;
    l1_num.delete(); l1_tc.delete();
    expect_req(3, 0, "R3");       pulse_sys();  drain("R3");
    expect_req(2, 0, "R3");       pulse_hp();   drain("R3");
    expect_req(0, tcv(0), "R3");  pulse_app(0); drain("R3");
    expect_req(1, tcv(1), "R3");  pulse_app(1); drain("R3");
    expect_req(1, tcv(1), "R5");  pulse_app(5); drain("R5");
    chk(l1_num.size() == 5, "R4", "shared log size", l1_num.size(), 5);
    if (l1_num.size() == 5) begin
      chk(l1_num[0] == 3 && l1_tc[0] == 0, "R4", "shared sys", l1_num[0], 3);
      chk(l1_num[1] == 3 && l1_tc[1] == 0, "R4", "shared hotplug", l1_num[1], 3);
      chk(l1_num[2] == 0 && l1_tc[2] == tcv(0), "R4", "shared app0", l1_num[2], 0);
      chk(l1_num[3] == 1 && l1_tc[3] == tcv(1), "R4", "shared app1", l1_num[3], 1);
      chk(l1_num[4] == 2 && l1_tc[4] == tcv(2), "R4", "shared app fold", l1_num[4], 2);
    end

    // R3 eight vectors, one vector, oversize code
    alloc_log2 = 3'd3;
    expect_req(5, tcv(5), "R3"); pulse_app(12); drain("R3");
    expect_req(6, 0, "R3");      pulse_hp();    drain("R3");
    alloc_log2 = 3'd0;
    expect_req(0, 0, "R3");      pulse_app(12); drain("R3");
    expect_req(0, 0, "R3");      pulse_sys();   drain("R3");
    alloc_log2 = 3'd7;
    expect_req(29, tcv(29), "R3"); pulse_app(29); drain("R3");
    expect_req(31, 0, "R3");       pulse_sys();   drain("R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule